// File: doc/BRIEF.md
# CMI-Violation Frame Realignment Inserter

This block sits in the bit-serial receive path between a line receiver and a standard E1 framer. Each bit period it takes the decoded positive and negative rail bits. It looks for the bipolar code violation that marks the first bit of a 256-bit private-network frame and restarts a bit-position counter on each one. The two rails are merged by OR into one unipolar stream, which is delayed through a shift register one slot wide.

The frame's time slot 16 carries nothing useful. When the counter shows that this slot has been fully captured, the shift register is parallel-loaded with an E1 alignment word instead of the captured bits. The word alternates between the frame-alignment pattern and the non-frame-alignment pattern on successive frames. A downstream E1 framer then locks to the synthetic word, and its alignment ends up half a frame away from the private-network frame. The modified stream is driven on both framer input rails, so the framer runs in unipolar mode. A lock indicator reports when the markers arrive at a steady frame spacing.

Top module: `cmi_realign_inserter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, both outputs and the lock flag are 0. Reset returns the bit position to 0 and makes the next inserted word the frame-alignment word.
- R2: A detected violation marks its own bit as frame position 0, wherever the counter stood before. Later bits are numbered from that point.
- R3: The data bit of each period is the OR of the two input rails, and both output rails always carry the same value.
- R4: Every bit outside the replaced slot reaches the outputs unchanged, exactly 8 clock cycles after it was sampled.
- R5: The bits at frame positions 128 to 135 (the slot that starts at the 129th bit) are replaced by the 8-bit alignment word, sent MSB first, with the same 8-cycle latency.
- R6: The inserted words alternate. The first word after reset is the frame-alignment word 8'b10011011, the next is the non-frame-alignment word 8'b11011111, and the pattern repeats from there.
- R7: With the both-rails violation rule (the default), a violation is a bit period with both rails high. Two marks in a row on the same rail are ordinary data.
- R8: With the same-rail violation rule, a violation is a single-rail mark of the same polarity as the previous single-rail mark. A period with both rails high is ordinary data and leaves the remembered polarity unchanged.
- R9: When no violation arrives, the position counter runs freely modulo 256, so a word is inserted every 256 bits.
- R10: The lock flag rises in the cycle after a violation that falls exactly 256 bits after the previous one. It falls in the cycle after a violation at any other position, or after frame position 0 passes without a violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock; one bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_pos_i | input | 1 | Decoded positive-rail bit from the line receiver |
| rx_neg_i | input | 1 | Decoded negative-rail bit from the line receiver |
| fr_pos_o | output | 1 | Realigned unipolar stream to the framer's positive input |
| fr_neg_o | output | 1 | Same stream to the framer's negative input |
| locked_o | output | 1 | High while markers keep arriving 256 bits apart |

## Verification
On every cycle, the assertions check that the counter restarts on a violation and otherwise advances or wraps. They check that each load places the expected word and flips the word selector, that the lock flag rises only after a marker at the wrap point and drops after a missed one, and that a same-rail violation comes with a single-rail mark. Only the bench scenarios can show the full end-to-end timing. That covers the 8-cycle data latency, the exact bit positions of the replaced slot, the FAS/NFAS order across many frames, and the difference between the two violation rules on identical rail patterns.

// File: rtl/cmi_realign_pkg.sv
`timescale 1ns/1ps
package cmi_realign_pkg;

   // Selects how a frame marker is recognised on the decoded rails.
   typedef enum logic {
      VIOL_BOTH_RAILS = 1'b0,  // both rails high in one bit period
      VIOL_SAME_RAIL  = 1'b1   // repeated single-rail mark of one polarity
   } viol_mode_e;

   // Alignment words, transmitted MSB first.
   localparam logic [7:0] FAS_DEFAULT  = 8'b1001_1011;
   localparam logic [7:0] NFAS_DEFAULT = 8'b1101_1111;

endpackage

// File: rtl/cmi_viol_detect.sv
`timescale 1ns/1ps
module cmi_viol_detect
   import cmi_realign_pkg::*;
#(
   parameter viol_mode_e MODE = VIOL_BOTH_RAILS
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pos_i,
   input  logic neg_i,
   output logic viol_o,
   output logic data_o
);

   // Unipolar merge of the two rails.
   assign data_o = pos_i | neg_i;

   generate
      if (MODE == VIOL_BOTH_RAILS) begin : g_both
         assign viol_o = pos_i & neg_i;
      end else begin : g_same
         logic last_pos_q;
         logic seen_q;
         logic single_pos;
         logic single_neg;

         assign single_pos = pos_i & ~neg_i;
         assign single_neg = neg_i & ~pos_i;

         // Remember the polarity of the latest single-rail mark only.
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               last_pos_q <= 1'b0;
               seen_q     <= 1'b0;
            end else if (single_pos | single_neg) begin
               last_pos_q <= single_pos;
               seen_q     <= 1'b1;
            end
         end

         assign viol_o = seen_q & ((single_pos & last_pos_q) |
                                   (single_neg & ~last_pos_q));

         // R8: a same-rail marker is always a single-rail mark.
         a_r8_single_rail_marker: assert property (@(posedge clk) disable iff (!rst_n)
            viol_o |-> (pos_i ^ neg_i));
      end
   endgenerate

   // R3: every marker bit is also a one in the merged stream.
   a_r3_marker_is_mark: assert property (@(posedge clk) disable iff (!rst_n)
      viol_o |-> data_o);

endmodule

// File: rtl/cmi_frame_counter.sv
`timescale 1ns/1ps
module cmi_frame_counter #(
   parameter int FRAME_BITS = 256,
   parameter int LOAD_POS   = 135
) (
   input  logic clk,
   input  logic rst_n,
   input  logic viol_i,
   output logic load_o,
   output logic locked_o
);

   localparam int CW = $clog2(FRAME_BITS);
   localparam logic [CW-1:0] LAST_POS = CW'(FRAME_BITS - 1);
   localparam logic [CW-1:0] LOAD_AT  = CW'(LOAD_POS);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] pos_now;
   logic          armed_q;
   logic          locked_q;

   // A marker claims position 0 for its own bit.
   assign pos_now = viol_i ? '0 : cnt_q;
   assign load_o  = (pos_now == LOAD_AT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (pos_now == LAST_POS) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= pos_now + 1'b1;
      end
   end

   // Lock: a marker exactly where the free-running count wraps, after a marker.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q  <= 1'b0;
         locked_q <= 1'b0;
      end else if (viol_i) begin
         locked_q <= armed_q & (cnt_q == '0);
         armed_q  <= 1'b1;
      end else if (cnt_q == '0) begin
         locked_q <= 1'b0;
         armed_q  <= 1'b0;
      end
   end

   assign locked_o = locked_q;

   a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
      viol_i |=> (cnt_q == CW'(1)));

   a_r9_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (!viol_i && cnt_q != LAST_POS) |=> (cnt_q == $past(cnt_q) + 1'b1));

   a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!viol_i && cnt_q == LAST_POS) |=> (cnt_q == '0));

   a_r10_lock_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_q) |-> ($past(viol_i) && $past(cnt_q) == '0));

   a_r10_lock_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (!viol_i && cnt_q == '0) |=> !locked_q);

endmodule

// File: rtl/cmi_slot_inserter.sv
`timescale 1ns/1ps
module cmi_slot_inserter #(
   parameter int                   SLOT_BITS = 8,
   parameter logic [SLOT_BITS-1:0] FAS_WORD  = 8'b1001_1011,
   parameter logic [SLOT_BITS-1:0] NFAS_WORD = 8'b1101_1111
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din_i,
   input  logic load_i,
   output logic dout_o
);

   logic [SLOT_BITS-1:0] sr_q;
   logic                 nfas_next_q;

   // Shift the merged stream; on load, drop the captured slot for a word.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr_q        <= '0;
         nfas_next_q <= 1'b0;
      end else if (load_i) begin
         sr_q        <= nfas_next_q ? NFAS_WORD : FAS_WORD;
         nfas_next_q <= ~nfas_next_q;
      end else begin
         sr_q        <= {sr_q[SLOT_BITS-2:0], din_i};
      end
   end

   assign dout_o = sr_q[SLOT_BITS-1];

   a_r5_word_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (sr_q == ($past(nfas_next_q) ? NFAS_WORD : FAS_WORD)));

   a_r6_alternate: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (nfas_next_q != $past(nfas_next_q)));

   a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(nfas_next_q));

endmodule

// File: rtl/cmi_realign_inserter.sv
`timescale 1ns/1ps
module cmi_realign_inserter
   import cmi_realign_pkg::*;
#(
   parameter int                   FRAME_BITS = 256,
   parameter int                   SLOT_BITS  = 8,
   parameter int                   SLOT_START = 129,   // 1-based first bit of the replaced slot
   parameter viol_mode_e           VIOL_MODE  = VIOL_BOTH_RAILS,
   parameter logic [SLOT_BITS-1:0] FAS_WORD   = FAS_DEFAULT,
   parameter logic [SLOT_BITS-1:0] NFAS_WORD  = NFAS_DEFAULT
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_pos_i,
   input  logic rx_neg_i,
   output logic fr_pos_o,
   output logic fr_neg_o,
   output logic locked_o
);

   // The load happens on the last bit of the slot, 0-based.
   localparam int LOAD_POS = SLOT_START + SLOT_BITS - 2;

   generate
      if (SLOT_BITS < 2) begin : g_bad_slot
         $error("SLOT_BITS must be at least 2");
      end
      if (SLOT_START < 1) begin : g_bad_start
         $error("SLOT_START is 1-based and must be at least 1");
      end
      if (LOAD_POS > FRAME_BITS - 1) begin : g_bad_fit
         $error("replaced slot must lie inside the frame");
      end
      if (FRAME_BITS < 2 * SLOT_BITS) begin : g_bad_frame
         $error("FRAME_BITS too small for the slot");
      end
   endgenerate

   logic viol;
   logic data;
   logic load;
   logic ser;

   cmi_viol_detect #(
      .MODE (VIOL_MODE)
   ) u_detect (
      .clk    (clk),
      .rst_n  (rst_n),
      .pos_i  (rx_pos_i),
      .neg_i  (rx_neg_i),
      .viol_o (viol),
      .data_o (data)
   );

   cmi_frame_counter #(
      .FRAME_BITS (FRAME_BITS),
      .LOAD_POS   (LOAD_POS)
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .viol_i   (viol),
      .load_o   (load),
      .locked_o (locked_o)
   );

   cmi_slot_inserter #(
      .SLOT_BITS (SLOT_BITS),
      .FAS_WORD  (FAS_WORD),
      .NFAS_WORD (NFAS_WORD)
   ) u_insert (
      .clk    (clk),
      .rst_n  (rst_n),
      .din_i  (data),
      .load_i (load),
      .dout_o (ser)
   );

   // Unipolar drive: the framer sees the same bit on both inputs.
   assign fr_pos_o = ser;
   assign fr_neg_o = ser;

endmodule

// File: tb/tb_cmi_realign_inserter.sv
`timescale 1ns/1ps
module tb_cmi_realign_inserter;
   import cmi_realign_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_pos = 1'b0;
   logic rx_neg = 1'b0;
   logic a_pos, a_neg, a_lk, b_pos, b_neg, b_lk;

   always #10 clk = ~clk;   // 50 MHz

   cmi_realign_inserter dut (
      .clk(clk), .rst_n(rst_n), .rx_pos_i(rx_pos), .rx_neg_i(rx_neg),
      .fr_pos_o(a_pos), .fr_neg_o(a_neg), .locked_o(a_lk));

   cmi_realign_inserter #(.VIOL_MODE(VIOL_SAME_RAIL)) dut_rep (
      .clk(clk), .rst_n(rst_n), .rx_pos_i(rx_pos), .rx_neg_i(rx_neg),
      .fr_pos_o(b_pos), .fr_neg_o(b_neg), .locked_o(b_lk));

   int    nvec = 0;
   int    nbad = 0;
   bit    rep = 1'b0;
   bit    done = 1'b0;
   string scn = "R1";

   // Reference model state
   int    pos_b, nloads, idx;
   bit    armed_m, lk_m, last_pos, have_pol;
   logic  ebuf [8];
   string tbuf [8];
   logic [15:0] lf = 16'hACE1;

   function automatic logic [7:0] word_for(int n);
      return (n % 2 == 0) ? 8'b1001_1011 : 8'b1101_1111;
   endfunction

   task automatic check_now();
      logic op, on, ol;
      op = rep ? b_pos : a_pos;
      on = rep ? b_neg : a_neg;
      ol = rep ? b_lk : a_lk;
      nvec++;
      if (op !== ebuf[idx % 8]) begin
         nbad++;
         $display("FAIL %s (%s) pos out: got %b exp %b", tbuf[idx % 8], scn, op, ebuf[idx % 8]);
      end
      nvec++;
      if (on !== ebuf[idx % 8]) begin
         nbad++;
         $display("FAIL R3 (%s) neg out: got %b exp %b", scn, on, ebuf[idx % 8]);
      end
      nvec++;
      if (ol !== lk_m) begin
         nbad++;
         $display("FAIL R10 (%s) locked: got %b exp %b", scn, ol, lk_m);
      end
   endtask

   // Update the model for a bit just driven; v says whether it is a marker.
   task automatic model(input logic p, input logic n, input bit v);
      int   fp;
      logic d;
      fp = v ? 0 : pos_b;
      d  = p | n;
      if (v) begin
         lk_m    = armed_m && (pos_b == 0);
         armed_m = 1'b1;
      end else if (pos_b == 0) begin
         lk_m    = 1'b0;
         armed_m = 1'b0;
      end
      if (fp >= 128 && fp <= 135) begin
         logic [7:0] w;
         w = word_for(nloads);
         ebuf[idx % 8] = w[7 - (fp - 128)];
         tbuf[idx % 8] = "R5 R6";
         if (fp == 135) nloads++;
      end else begin
         ebuf[idx % 8] = d;
         tbuf[idx % 8] = "R4";
      end
      idx++;
      pos_b = (fp + 1) % 256;
   endtask

   task automatic put(input logic p, input logic n, input bit v);
      @(negedge clk);
      check_now();
      rx_pos = p;
      rx_neg = n;
      model(p, n, v);
   endtask

   task automatic data_bit(input logic b);
      if (!b) put(1'b0, 1'b0, 1'b0);
      else begin
         if (!have_pol) begin last_pos = 1'b1; have_pol = 1'b1; end
         else last_pos = ~last_pos;
         put(last_pos, ~last_pos, 1'b0);
      end
   endtask

   task automatic run_data(input int n);
      for (int i = 0; i < n; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         data_bit(lf[0]);
      end
   endtask

   // Frame marker according to the active rule.
   task automatic marker();
      if (!rep) put(1'b1, 1'b1, 1'b1);
      else put(last_pos, ~last_pos, 1'b1);
   endtask

   task automatic do_reset(input bit sel);
      @(negedge clk);
      rst_n = 1'b0; rx_pos = 1'b0; rx_neg = 1'b0; rep = sel;
      repeat (3) @(negedge clk);
      scn = "R1";
      nvec++;
      if ({(sel ? b_pos : a_pos), (sel ? b_neg : a_neg), (sel ? b_lk : a_lk)} !== 3'b000) begin
         nbad++;
         $display("FAIL R1 reset outputs: got %b%b%b exp 000",
                  sel ? b_pos : a_pos, sel ? b_neg : a_neg, sel ? b_lk : a_lk);
      end
      pos_b = 0; nloads = 0; idx = 0; armed_m = 0; lk_m = 0; have_pol = 0; last_pos = 0;
      for (int i = 0; i < 8; i++) begin ebuf[i] = 1'b0; tbuf[i] = "R1"; end
      @(negedge clk);
      rst_n = 1'b1;
      model(1'b0, 1'b0, 1'b0);   // first bit after release
   endtask

   initial begin
      // Phase A: both-rails rule
      do_reset(1'b0);
      scn = "R9"; run_data(600);           // two free-running insertions: FAS then NFAS
      scn = "R2"; run_data(37); marker();  // restart off the free-running grid
      run_data(255); marker();             // 256 apart: lock
      run_data(255); marker();
      scn = "R7";
      run_data(50);
      data_bit(1'b1); put(last_pos, ~last_pos, 1'b0);  // same-rail repeat is plain data
      run_data(203); marker();             // still on grid: lock kept
      scn = "R10";
      run_data(20); marker();              // off-position marker drops lock
      run_data(255); marker();             // relock
      run_data(300);                       // missed marker drops lock
      // Phase B: same-rail rule
      do_reset(1'b1);
      scn = "R8";
      data_bit(1'b1); run_data(30); marker();
      run_data(100);
      put(1'b1, 1'b1, 1'b0);               // both rails high: plain data here
      run_data(154); marker();             // 256 after previous marker
      run_data(255); marker();
      run_data(300);
      @(negedge clk); check_now();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         nbad++;
         $display("FAIL watchdog expired in %s", scn);
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

endmodule